// File: doc/BRIEF.md
# Power Mode Clock Controller

This block runs on the always-on slow clock and decides which clocks in the system may run. It holds one of four power modes: normal, idle, slow-clock and standby. From that mode it drives a processor clock enable, a main oscillator enable, a PLL enable and a master clock source select. It also keeps a bank of peripheral clock enables that software sets and clears one bit at a time. The clock trees themselves lie outside the block and take these signals as gate enables and mux selects.

Software requests a mode through a small word-addressed write/read bus. Idle and standby are left when an interrupt arrives. Idle returns to normal, and standby returns to slow-clock. Moving from a slow-clock based mode to a PLL-based mode is not immediate. The block raises the oscillator and PLL enables, reports busy, and keeps the master clock on the slow clock until the PLL lock input has been seen high for `LOCK_CYCLES` consecutive cycles. Mode requests that arrive during that wait are dropped.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While reset is asserted and just after it is released, the mode is slow-clock (code 2), busy is 0, the oscillator and PLL enables are 0, the master clock select is 0 (slow clock), the processor clock enable is 1, and all peripheral enables are 0.
- R2: The processor clock enable is 1 in normal (code 0) and slow-clock (code 2), and 0 in idle (code 1) and standby (code 3).
- R3: In slow-clock and standby with no pending transition, the oscillator enable, the PLL enable and the master clock select are all 0. In normal and idle, all three are 1.
- R4: A mode write (address 0, code in bits 1:0) that moves from slow-clock or standby to normal or idle does not change the mode at once. Busy becomes 1 and the oscillator and PLL enables become 1, and the master clock select stays 0. The target mode is entered, and busy clears, at the clock edge where pll_lock_i is sampled high for the `LOCK_CYCLES`-th consecutive time (default 2) since the request.
- R5: A low sample of pll_lock_i during the wait restarts the consecutive count from zero.
- R6: A mode write while busy is 1 is ignored: neither the current mode nor the pending target changes.
- R7: A sampled irq_i moves idle to normal and standby to slow-clock in one cycle. In normal and slow-clock it has no effect.
- R8: Writing address 1 sets every peripheral enable whose data bit is 1. Writing address 2 clears every enable whose data bit is 1. Bits written as 0 keep their value.
- R9: Peripheral enables keep their programmed values through every mode change, including idle and standby.
- R10: Reads are combinational on addr_i. Address 0 returns the mode code in bits 1:0 and busy in bit 8. Address 3 returns the peripheral enables in bits NP-1:0. Addresses 1 and 2 read as zero.
- R11: When a mode write is accepted in the same cycle as an interrupt, the write decides the next mode and the wake-up is dropped.
- R12: Transitions that do not leave a slow-clock based mode for a PLL-based one take effect in the cycle after the write: normal or idle to any mode, slow-clock to standby, and standby to slow-clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow clock, always running |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | AW | Word address of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| irq_i | input | 1 | Interrupt request, wakes from idle and standby |
| pll_lock_i | input | 1 | PLL lock indication |
| cpu_clk_en_o | output | 1 | Processor clock gate enable |
| periph_clk_en_o | output | NP | Peripheral clock gate enables |
| osc_en_o | output | 1 | Main oscillator enable |
| pll_en_o | output | 1 | PLL enable |
| mck_sel_o | output | 1 | Master clock select: 0 slow clock, 1 PLL clock |
| mode_o | output | 2 | Current mode code |
| busy_o | output | 1 | Transition to a PLL-based mode pending |

## Verification
The assertions check several properties on every cycle. The master clock select only rises once a full run of lock samples has been seen. Slow-clock based modes keep the oscillator and master clock off. Busy only rises with the PLL enabled while the slow clock is still selected. Idle always answers an interrupt. Peripheral enables stay put without a bus write. The bench's scenarios are needed for the rest. They show that an interrupted lock run restarts, that writes during busy are dropped, the write-over-interrupt priority, the exact set and clear semantics, and the register read layout. A behavioural model compared on every clock covers the sequences between those scenarios.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_SLOW    = 2'd2,
    MODE_STANDBY = 2'd3
  } pm_mode_e;

  localparam int unsigned REG_MODE  = 0;
  localparam int unsigned REG_PSET  = 1;
  localparam int unsigned REG_PCLR  = 2;
  localparam int unsigned REG_PSTAT = 3;
  localparam int unsigned BUSY_BIT  = 8;

  // bit 1 of the code marks a slow-clock based mode
  function automatic logic slow_based(pm_mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/pmc_periph_en.sv
module pmc_periph_en #(
  parameter int unsigned NP = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] set_i,
  input  logic [NP-1:0] clr_i,
  output logic [NP-1:0] en_o
);
  for (genvar i = 0; i < NP; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_o[i] <= 1'b0;
      else if (clr_i[i]) en_o[i] <= 1'b0;
      else if (set_i[i]) en_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/pmc_lock_filter.sv
module pmc_lock_filter #(
  parameter int unsigned LOCK_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic lock_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = arm_i && lock_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (!arm_i || !lock_i || done_o) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  pm_mode_e req_mode_i,
  input  logic     irq_i,
  input  logic     lock_done_i,
  output pm_mode_e mode_o,
  output logic     busy_o
);
  pm_mode_e mode_q, mode_d, tgt_q, tgt_d;
  logic     busy_q, busy_d;
  logic     accept;

  assign accept = req_valid_i && !busy_q;

  always_comb begin
    mode_d = mode_q;
    tgt_d  = tgt_q;
    busy_d = busy_q;
    if (accept) begin
      if (slow_based(mode_q) && !slow_based(req_mode_i)) begin
        busy_d = 1'b1;
        tgt_d  = req_mode_i;
      end else begin
        mode_d = req_mode_i;
      end
    end else begin
      if (irq_i) begin
        if (mode_q == MODE_IDLE)         mode_d = MODE_NORMAL;
        else if (mode_q == MODE_STANDBY) mode_d = MODE_SLOW;
      end
      if (busy_q && lock_done_i) begin
        mode_d = tgt_q;
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLOW;
      tgt_q  <= MODE_NORMAL;
      busy_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      tgt_q  <= tgt_d;
      busy_q <= busy_d;
    end
  end

  assign mode_o = mode_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned NP          = 8,  // 1..DW
  parameter int unsigned AW          = 3,
  parameter int unsigned DW          = 32,
  parameter int unsigned LOCK_CYCLES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          irq_i,
  input  logic          pll_lock_i,
  output logic          cpu_clk_en_o,
  output logic [NP-1:0] periph_clk_en_o,
  output logic          osc_en_o,
  output logic          pll_en_o,
  output logic          mck_sel_o,
  output logic [1:0]    mode_o,
  output logic          busy_o
);
  logic          sel_mode, sel_set, sel_clr;
  logic [NP-1:0] set_v, clr_v;
  logic          lock_done;
  pm_mode_e      mode;
  logic          busy;

  assign sel_mode = wr_en_i && (addr_i == AW'(REG_MODE));
  assign sel_set  = wr_en_i && (addr_i == AW'(REG_PSET));
  assign sel_clr  = wr_en_i && (addr_i == AW'(REG_PCLR));
  assign set_v    = sel_set ? wdata_i[NP-1:0] : '0;
  assign clr_v    = sel_clr ? wdata_i[NP-1:0] : '0;

  pmc_periph_en #(.NP(NP)) u_periph (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .en_o   (periph_clk_en_o)
  );

  pmc_lock_filter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (busy),
    .lock_i (pll_lock_i),
    .done_o (lock_done)
  );

  pmc_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (sel_mode),
    .req_mode_i  (pm_mode_e'(wdata_i[1:0])),
    .irq_i       (irq_i),
    .lock_done_i (lock_done),
    .mode_o      (mode),
    .busy_o      (busy)
  );

  assign cpu_clk_en_o = (mode == MODE_NORMAL) || (mode == MODE_SLOW);
  assign osc_en_o     = busy || !slow_based(mode);
  assign pll_en_o     = busy || !slow_based(mode);
  assign mck_sel_o    = !slow_based(mode);
  assign mode_o       = mode;
  assign busy_o       = busy;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(REG_MODE): begin
        rdata_o[1:0]     = mode;
        rdata_o[BUSY_BIT] = busy;
      end
      AW'(REG_PSTAT): rdata_o[NP-1:0] = periph_clk_en_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_clk_ctrl_checker.sv
module pwr_clk_ctrl_checker #(
  parameter int unsigned NP          = 8,
  parameter int unsigned AW          = 3,
  parameter int unsigned LOCK_CYCLES = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic          irq_i,
  input logic          pll_lock_i,
  input logic          cpu_clk_en_o,
  input logic [NP-1:0] periph_clk_en_o,
  input logic          osc_en_o,
  input logic          pll_en_o,
  input logic          mck_sel_o,
  input logic [1:0]    mode_o,
  input logic          busy_o
);
  localparam int unsigned RW = $clog2(LOCK_CYCLES + 1) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         run_q <= '0;
    else if (!pll_lock_i)                run_q <= '0;
    else if (run_q < RW'(LOCK_CYCLES))   run_q <= run_q + 1'b1;
  end

  AST_MCK_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mck_sel_o) |-> (run_q >= RW'(LOCK_CYCLES)) && $fell(busy_o)); // R4

  AST_SLOW_MODES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && !busy_o) |-> (!osc_en_o && !pll_en_o && !mck_sel_o)); // R3

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (pll_en_o && osc_en_o && !mck_sel_o && mode_o[1])); // R4

  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && irq_i && !(wr_en_i && addr_i == '0)) |=> (mode_o == 2'd0)); // R7

  AST_PERIPH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(periph_clk_en_o)); // R9

  AST_CPU_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_clk_en_o) |-> mode_o[0]); // R2
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_checker #(
  .NP(NP), .AW(AW), .LOCK_CYCLES(LOCK_CYCLES)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .addr_i          (addr_i),
  .irq_i           (irq_i),
  .pll_lock_i      (pll_lock_i),
  .cpu_clk_en_o    (cpu_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .osc_en_o        (osc_en_o),
  .pll_en_o        (pll_en_o),
  .mck_sel_o       (mck_sel_o),
  .mode_o          (mode_o),
  .busy_o          (busy_o)
);

// File: tb/pwr_clk_ctrl_test.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_test;
  localparam int NP = 8;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam int LOCK = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq = 1'b0;
  logic          lock = 1'b0;
  logic          cpu_en, osc_en, pll_en, mck_sel, busy;
  logic [NP-1:0] per_en;
  logic [1:0]    mode;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  pwr_clk_ctrl #(.NP(NP), .AW(AW), .DW(DW), .LOCK_CYCLES(LOCK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .pll_lock_i(lock),
    .cpu_clk_en_o(cpu_en), .periph_clk_en_o(per_en), .osc_en_o(osc_en),
    .pll_en_o(pll_en), .mck_sel_o(mck_sel), .mode_o(mode), .busy_o(busy)
  );

  // behavioural reference
  int m_mode, m_tgt, m_run;
  bit m_busy;
  logic [NP-1:0] m_per;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2; m_tgt = 0; m_run = 0; m_busy = 0; m_per = '0;
    end else begin
      bit acc, fin;
      int req;
      req = int'(wdata[1:0]);
      acc = wr_en && addr == 0 && !m_busy;
      fin = m_busy && lock && (m_run == LOCK - 1);
      m_run = (m_busy && lock && !fin) ? m_run + 1 : 0;
      if (wr_en && addr == 1) m_per = m_per | wdata[NP-1:0];
      if (wr_en && addr == 2) m_per = m_per & ~wdata[NP-1:0];
      if (acc) begin
        if (m_mode >= 2 && req < 2) begin m_busy = 1; m_tgt = req; end
        else m_mode = req;
      end else begin
        if (irq && m_mode == 1) m_mode = 0;
        else if (irq && m_mode == 3) m_mode = 2;
        if (fin) begin m_mode = m_tgt; m_busy = 0; end
      end
    end
  end

  function automatic logic [DW-1:0] exp_rdata(logic [AW-1:0] a);
    logic [DW-1:0] r = '0;
    if (a == 0) begin r[1:0] = 2'(m_mode); r[8] = m_busy; end
    else if (a == 3) r[NP-1:0] = m_per;
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) begin
    logic [DW-1:0] act, exp;
    act = {rdata[15:0], 2'b0, per_en, cpu_en, osc_en, pll_en, mck_sel, busy, mode};
    exp = {exp_rdata(addr)[15:0], 2'b0, m_per,
           1'(m_mode == 0 || m_mode == 2), 1'(m_busy || m_mode < 2),
           1'(m_busy || m_mode < 2), 1'(m_mode < 2), m_busy, 2'(m_mode)};
    chk({"model/", phase}, act, exp);
  end

  // one cycle: drive after the falling edge, return at the next falling edge
  task automatic cyc(bit w, int a, int d, bit i, bit l);
    #1;
    wr_en = w; addr = AW'(a); wdata = DW'(d); irq = i; lock = l;
    @(negedge clk);
  endtask

  task automatic idle_cyc(int n, bit l);
    for (int k = 0; k < n; k++) cyc(0, 3, 0, 0, l);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cmp_on = 1;
    @(negedge clk);
    phase = "R1";
    chk("R1 mode", DW'(mode), 2);
    chk("R1 clocks", DW'({cpu_en, osc_en, pll_en, mck_sel, busy}), DW'(5'b10000));
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 periph", DW'(per_en), 0);

    phase = "R8";
    cyc(1, 1, 'hA5, 0, 0);
    chk("R8 set", DW'(per_en), 'hA5);
    cyc(1, 2, 'h21, 0, 0);
    chk("R8 clear", DW'(per_en), 'h84);
    cyc(1, 1, 'h01, 0, 0);
    chk("R8 set keeps", DW'(per_en), 'h85);
    phase = "R10";
    cyc(0, 3, 0, 0, 0);
    chk("R10 status", rdata, 'h85);
    cyc(0, 1, 0, 0, 0);
    chk("R10 set reg reads 0", rdata, 0);

    phase = "R4";
    cyc(1, 0, 0, 0, 0);
    chk("R4 busy", DW'({busy, pll_en, osc_en, mck_sel, mode}), DW'({4'b1110, 2'd2}));
    idle_cyc(3, 0);
    chk("R4 waits for lock", DW'({busy, mck_sel}), DW'(2'b10));
    phase = "R6";
    cyc(1, 0, 3, 0, 0);
    chk("R6 ignored", DW'({busy, mode}), DW'({1'b1, 2'd2}));
    phase = "R5";
    idle_cyc(1, 1);
    idle_cyc(1, 0);
    idle_cyc(1, 1);
    chk("R5 restart", DW'({busy, mck_sel}), DW'(2'b10));
    idle_cyc(1, 1);
    chk("R4 locked", DW'({busy, mck_sel, mode}), DW'({2'b01, 2'd0}));
    cyc(0, 0, 0, 0, 0);
    chk("R10 mode reg", rdata, 0);

    phase = "R12";
    cyc(1, 0, 1, 0, 0);
    chk("R2 idle gates cpu", DW'({cpu_en, mck_sel, mode}), DW'({2'b01, 2'd1}));
    chk("R9 idle keeps periph", DW'(per_en), 'h85);
    phase = "R7";
    cyc(0, 3, 0, 1, 0);
    chk("R7 idle wake", DW'({cpu_en, mode}), DW'({1'b1, 2'd0}));
    cyc(0, 3, 0, 1, 0);
    chk("R7 normal no effect", DW'(mode), 0);

    phase = "R3";
    cyc(1, 0, 3, 0, 0);
    chk("R3 standby off", DW'({cpu_en, osc_en, pll_en, mck_sel, mode}), DW'({4'b0000, 2'd3}));
    chk("R9 standby keeps periph", DW'(per_en), 'h85);
    cyc(0, 3, 0, 1, 0);
    chk("R7 standby wake", DW'({cpu_en, mode}), DW'({1'b1, 2'd2}));
    cyc(0, 3, 0, 1, 0);
    chk("R7 slow no effect", DW'(mode), 2);

    phase = "R11";
    cyc(1, 0, 1, 0, 1);
    idle_cyc(2, 1);
    chk("R4 idle after lock", DW'({busy, mck_sel, cpu_en, mode}), DW'({3'b010, 2'd1}));
    cyc(1, 0, 2, 1, 0);
    chk("R11 write beats wake", DW'(mode), 2);
    cyc(1, 0, 3, 0, 0);
    chk("R12 slow to standby", DW'(mode), 3);
    cyc(1, 0, 0, 1, 0);
    chk("R11 accepted write, no wake", DW'({busy, cpu_en, mode}), DW'({2'b10, 2'd3}));
    cyc(0, 3, 0, 1, 0);
    chk("R7 wake while pending", DW'({busy, cpu_en, mode}), DW'({2'b11, 2'd2}));
    idle_cyc(2, 1);
    chk("R4 complete", DW'({busy, mode}), DW'({1'b0, 2'd0}));
    cyc(1, 2, 'hFF, 0, 0);
    chk("R8 clear all", DW'(per_en), 0);
    idle_cyc(2, 0);
    finish_run();
  end
endmodule